// File: doc/BRIEF.md
# Timing Pulse and Interval Generator

This block produces the level on the timing-pulse pin of a real-time clock. In its square-wave mode it passes one of four divider taps (64 Hz, 256 Hz, 2048 Hz or 4096 Hz) straight to the pin. In its interval mode it shows the output flag of a timer that counts 1/64 s base ticks and toggles once every half interval. The result is a 50% duty wave whose period is 1, 10, 30 or 60 seconds. The timer has no link to the calendar counters.

The command decoder upstream presents a 4-bit command with a one-cycle valid strobe. It also raises a flag when the command came from the 3-bit parallel pin path. That path can only select the three lower frequencies and hold the register. Selecting a frequency from that path also stops the interval timer. Commands 1100, 1101 and 1110 act only on the timer: they clear the flag, restart the timer and freeze it. Command 1111 enters a test state in which the pin is held low. A register-hold command cancels that state and returns the pin to 64 Hz.

Top module: `tp_pulse_gen`

## Requirements
- R1: After reset the pin follows the 64 Hz tap (`div_tap_i[0]`), square-wave mode is active, the interval timer is stopped and its flag is low.
- R2: Commands 0100, 0101, 0110 and 0111 select `div_tap_i[0]`, `[1]`, `[2]` and `[3]` (64, 256, 2048 and 4096 Hz), and the pin then equals that tap. From the parallel path, code 0111 and every code with bit 3 set are ignored.
- R3: Commands 1000, 1001, 1010 and 1011 select 1, 10, 30 and 60 s. Each clears the count and the flag, starts the timer and switches the pin to the flag.
- R4: While the timer runs, the flag toggles after every seconds x 32 base ticks. This gives a 50% square wave of seconds x 64 ticks per period.
- R5: Command 1100 clears the flag and leaves the count running, so the next toggle comes at the same tick as it would have without the command.
- R6: Command 1101 clears the count and the flag and starts the timer. Command 1110 stops the timer: the count freezes and the flag keeps its level.
- R7: A frequency selection from the parallel path stops the timer. A frequency selection from the serial path leaves the timer running in the background.
- R8: Command 1111 enters test mode, which holds the pin low. Commands 0100 to 1110 leave test mode. Command 0000 in test mode leaves it and selects 64 Hz square-wave mode. Command 0000 outside test mode has no effect.
- R9: A command that falls on a base-tick cycle takes precedence over the count. Commands 1000 to 1011, 1101 and 1110 discard the tick. Command 1100 lets the tick count and still leaves the flag low.
- R10: Commands 0001, 0010 and 0011 (shift, time set, time read) change neither the pin nor the interval timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid_i | input | 1 | One-cycle strobe for `cmd_code_i` |
| cmd_par_i | input | 1 | Command came from the parallel pin path |
| cmd_code_i | input | 4 | Decoded command code |
| div_tap_i | input | 4 | Divider tap levels: [0] 64 Hz, [1] 256 Hz, [2] 2048 Hz, [3] 4096 Hz |
| tick_i | input | 1 | One-cycle pulse every 1/64 s |
| tp_o | output | 1 | Timing-pulse level |

## Verification
A base tick and a timer command can land in the same clock cycle. Each command has its own rule for whether that tick counts, and an off-by-one in the flag position follows from any mistake. The bench drives ticks on every even cycle and moves each command between even and odd cycles. Some commands therefore coincide with a tick and others do not. The bench's own tick-by-tick model predicts the pin level, and that prediction is compared on every cycle, including the toggle that falls right after a flag-clear.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // divider tap index, bit position in div_tap_i
  typedef enum logic [1:0] {
    TAP_64  = 2'd0,
    TAP_256 = 2'd1,
    TAP_2K  = 2'd2,
    TAP_4K  = 2'd3
  } tap_sel_e;

  typedef enum logic [1:0] {
    IVL_1S  = 2'd0,
    IVL_10S = 2'd1,
    IVL_30S = 2'd2,
    IVL_60S = 2'd3
  } ivl_sel_e;

  // one-hot-ish decoded operation for one accepted command
  typedef struct packed {
    logic     sel_freq;
    tap_sel_e tap;
    logic     sel_ivl;
    ivl_sel_e ivl;
    logic     flag_clr;
    logic     run;
    logic     stop;
    logic     enter_test;
    logic     leave_test;
    logic     hold;
  } tp_op_t;

endpackage

// File: rtl/tp_cmd_decode.sv
module tp_cmd_decode
  import tp_pkg::*;
(
  input  logic       cmd_valid_i,
  input  logic       cmd_par_i,
  input  logic [3:0] cmd_code_i,
  output tp_op_t     op_o
);

  logic accept;

  // parallel path reaches only codes 0000..0110
  assign accept = cmd_valid_i &&
                  !(cmd_par_i && (cmd_code_i[3] || (cmd_code_i == 4'b0111)));

  always_comb begin
    op_o = '0;
    if (accept) begin
      casez (cmd_code_i)
        4'b0000: op_o.hold = 1'b1;
        4'b01??: begin
          op_o.sel_freq   = 1'b1;
          op_o.tap        = tap_sel_e'(cmd_code_i[1:0]);
          op_o.stop       = cmd_par_i;
          op_o.leave_test = 1'b1;
        end
        4'b10??: begin
          op_o.sel_ivl    = 1'b1;
          op_o.ivl        = ivl_sel_e'(cmd_code_i[1:0]);
          op_o.leave_test = 1'b1;
        end
        4'b1100: begin
          op_o.flag_clr   = 1'b1;
          op_o.leave_test = 1'b1;
        end
        4'b1101: begin
          op_o.run        = 1'b1;
          op_o.leave_test = 1'b1;
        end
        4'b1110: begin
          op_o.stop       = 1'b1;
          op_o.leave_test = 1'b1;
        end
        4'b1111: op_o.enter_test = 1'b1;
        default: op_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/tp_ivl_timer.sv
module tp_ivl_timer
  import tp_pkg::*;
#(
  parameter int TICKS_PER_SEC = 64,
  localparam int HALF_MAX     = 30 * TICKS_PER_SEC,
  localparam int CNT_W        = $clog2(HALF_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  ivl_sel_e         ivl_i,
  input  logic             flag_clr_i,
  input  logic             run_i,
  input  logic             stop_i,
  output logic             flag_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_n, half_m1;
  logic             flag_q, flag_n, run_q, run_n;
  ivl_sel_e         ivl_q, ivl_n;
  logic             en;

  always_comb begin
    case (ivl_q)
      IVL_1S:  half_m1 = CNT_W'(TICKS_PER_SEC / 2 - 1);
      IVL_10S: half_m1 = CNT_W'(5 * TICKS_PER_SEC - 1);
      IVL_30S: half_m1 = CNT_W'(15 * TICKS_PER_SEC - 1);
      default: half_m1 = CNT_W'(30 * TICKS_PER_SEC - 1);
    endcase
  end

  assign en = (run_q && tick_i) || load_i || flag_clr_i || run_i || stop_i;

  always_comb begin
    cnt_n  = cnt_q;
    flag_n = flag_q;
    run_n  = run_q;
    ivl_n  = ivl_q;
    if (load_i) begin
      ivl_n  = ivl_i;
      cnt_n  = '0;
      flag_n = 1'b0;
      run_n  = 1'b1;
    end else if (run_i) begin
      cnt_n  = '0;
      flag_n = 1'b0;
      run_n  = 1'b1;
    end else if (stop_i) begin
      run_n  = 1'b0;
    end else begin
      if (run_q && tick_i) begin
        if (cnt_q == half_m1) begin
          cnt_n  = '0;
          flag_n = ~flag_q;
        end else begin
          cnt_n  = cnt_q + 1'b1;
        end
      end
      if (flag_clr_i) flag_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      run_q  <= 1'b0;
      ivl_q  <= IVL_1S;
    end else if (en) begin
      cnt_q  <= cnt_n;
      flag_q <= flag_n;
      run_q  <= run_n;
      ivl_q  <= ivl_n;
    end
  end

  assign flag_o = flag_q;
  assign run_o  = run_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/tp_out_sel.sv
module tp_out_sel
  import tp_pkg::*;
#(
  parameter int N_TAPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tp_op_t            op_i,
  input  logic [N_TAPS-1:0] div_tap_i,
  input  logic              flag_i,
  output logic              test_o,
  output logic              tp_o
);

  tap_sel_e tap_q, tap_n;
  logic     ivl_mode_q, ivl_mode_n;
  logic     test_q, test_n;
  logic     en;

  assign en = op_i.sel_freq || op_i.sel_ivl || op_i.leave_test ||
              op_i.enter_test || op_i.hold;

  always_comb begin
    tap_n      = tap_q;
    ivl_mode_n = ivl_mode_q;
    test_n     = test_q;
    if (op_i.sel_freq) begin
      tap_n      = op_i.tap;
      ivl_mode_n = 1'b0;
    end
    if (op_i.sel_ivl)    ivl_mode_n = 1'b1;
    if (op_i.leave_test) test_n     = 1'b0;
    if (op_i.enter_test) test_n     = 1'b1;
    if (op_i.hold && test_q) begin
      test_n     = 1'b0;
      tap_n      = TAP_64;
      ivl_mode_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q      <= TAP_64;
      ivl_mode_q <= 1'b0;
      test_q     <= 1'b0;
    end else if (en) begin
      tap_q      <= tap_n;
      ivl_mode_q <= ivl_mode_n;
      test_q     <= test_n;
    end
  end

  assign test_o = test_q;
  assign tp_o   = test_q ? 1'b0 : (ivl_mode_q ? flag_i : div_tap_i[tap_q]);

endmodule

// File: rtl/tp_pulse_gen.sv
module tp_pulse_gen
  import tp_pkg::*;
#(
  parameter int TICKS_PER_SEC = 64,
  parameter int N_TAPS        = 4,
  localparam int CNT_W        = $clog2(30 * TICKS_PER_SEC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic              cmd_par_i,
  input  logic [3:0]        cmd_code_i,
  input  logic [N_TAPS-1:0] div_tap_i,
  input  logic              tick_i,
  output logic              tp_o
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  tp_op_t           op;
  logic             ivl_flag, ivl_run, test_q;
  logic [CNT_W-1:0] ivl_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  tp_cmd_decode u_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_par_i   (cmd_par_i),
    .cmd_code_i  (cmd_code_i),
    .op_o        (op)
  );

  tp_ivl_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .load_i     (op.sel_ivl),
    .ivl_i      (op.ivl),
    .flag_clr_i (op.flag_clr),
    .run_i      (op.run),
    .stop_i     (op.stop),
    .flag_o     (ivl_flag),
    .run_o      (ivl_run),
    .cnt_o      (ivl_cnt)
  );

  tp_out_sel #(.N_TAPS(N_TAPS)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op_i      (op),
    .div_tap_i (div_tap_i),
    .flag_i    (ivl_flag),
    .test_o    (test_q),
    .tp_o      (tp_o)
  );

endmodule

// File: rtl/tp_pulse_gen_chk.sv
module tp_pulse_gen_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_par,
  input logic [3:0]       cmd_code,
  input logic             tap64,
  input logic             tp,
  input logic             op_any,
  input logic             op_sel_ivl,
  input logic             op_flag_clr,
  input logic             op_stop,
  input logic             op_run,
  input logic             ivl_flag,
  input logic             ivl_run,
  input logic [CNT_W-1:0] ivl_cnt,
  input logic             test_q
);

  AST_PAR_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_par && (cmd_code[3] || cmd_code == 4'b0111)) |-> !op_any); // R2

  AST_IVL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel_ivl |=> (ivl_cnt == '0) && !ivl_flag && ivl_run); // R3

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    op_flag_clr |=> !ivl_flag && $stable(ivl_run)); // R5

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    op_run |=> (ivl_cnt == '0) && ivl_run); // R6

  AST_STOP_HOLDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_stop |=> !ivl_run && $stable(ivl_flag)); // R6

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ivl_run && !op_sel_ivl && !op_run) |=> $stable(ivl_cnt)); // R6

  AST_PAR_FREQ_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_par && cmd_code[3:2] == 2'b01 && cmd_code[1:0] != 2'b11)
    |=> !ivl_run); // R7

  AST_TEST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    test_q |-> !tp); // R8

  AST_HOLD_BACK_64: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 4'b0000 && test_q) |=> !test_q && (tp == tap64)); // R8

endmodule

bind tp_pulse_gen tp_pulse_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cmd_valid   (cmd_valid_i),
  .cmd_par     (cmd_par_i),
  .cmd_code    (cmd_code_i),
  .tap64       (div_tap_i[0]),
  .tp          (tp_o),
  .op_any      (|op),
  .op_sel_ivl  (op.sel_ivl),
  .op_flag_clr (op.flag_clr),
  .op_stop     (op.stop),
  .op_run      (op.run),
  .ivl_flag    (ivl_flag),
  .ivl_run     (ivl_run),
  .ivl_cnt     (ivl_cnt),
  .test_q      (test_q)
);

// File: tb/tp_pulse_gen_tb_top.sv
module tp_pulse_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid_i, cmd_par_i, tick_i, tp_o;
  logic [3:0] cmd_code_i, div_tap_i;

  always #4 clk = ~clk;   // 125 MHz

  tp_pulse_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_par_i   (cmd_par_i),
    .cmd_code_i  (cmd_code_i),
    .div_tap_i   (div_tap_i),
    .tick_i      (tick_i),
    .tp_o        (tp_o)
  );

  int    cyc = 0, n_chk = 0, n_fail = 0;
  bit    cmp_en = 0, tick_en = 0, done = 0;
  string phase = "R1";

  // behavioural reference state
  int m_sel, m_ivl, m_test, m_run, m_cnt, m_flag, m_half;

  function automatic int exp_tp();
    if (m_test != 0) return 0;
    if (m_ivl != 0)  return m_flag;
    return int'(div_tap_i[m_sel]);
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: tp actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int c;
    cyc++;
    if (!rst_n) begin
      m_sel = 0; m_ivl = 0; m_test = 0; m_run = 0;
      m_cnt = 0; m_flag = 0; m_half = 32;
    end else begin
      c = -1;
      if (cmd_valid_i && !(cmd_par_i && (cmd_code_i >= 7))) c = int'(cmd_code_i);
      if (c >= 8 && c <= 11) begin
        m_half = (c == 8 ? 1 : c == 9 ? 10 : c == 10 ? 30 : 60) * 32;
        m_cnt = 0; m_flag = 0; m_run = 1;
      end else if (c == 13) begin
        m_cnt = 0; m_flag = 0; m_run = 1;
      end else if (c == 14 || (cmd_par_i && c >= 4 && c <= 6)) begin
        m_run = 0;
      end else begin
        if (m_run != 0 && tick_i) begin
          m_cnt++;
          if (m_cnt == m_half) begin m_cnt = 0; m_flag = 1 - m_flag; end
        end
        if (c == 12) m_flag = 0;
      end
      if (c >= 4 && c <= 7) begin m_sel = c - 4; m_ivl = 0; end
      if (c >= 8 && c <= 11) m_ivl = 1;
      if (c >= 4 && c <= 14) m_test = 0;
      if (c == 15) m_test = 1;
      if (c == 0 && m_test != 0) begin m_test = 0; m_sel = 0; m_ivl = 0; end
    end
  end

  // compare first, then move the taps and the tick
  always @(negedge clk) begin
    if (cmp_en) check(int'(tp_o), exp_tp(), phase);
    div_tap_i = {cyc[0], cyc[1], cyc[3], cyc[4]};
    tick_i    = tick_en && (cyc % 2 == 0);
  end

  task automatic send(input logic [3:0] c, input logic p);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_code_i = c; cmd_par_i = p;
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_par_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid_i = 1'b0; cmd_par_i = 1'b0; cmd_code_i = 4'h0;
    div_tap_i = 4'h0; tick_i = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state, 64 Hz tap, timer idle
    phase = "R1";
    cmp_en = 1;
    check(int'(tp_o), int'(div_tap_i[0]), "R1");
    tick_en = 1;
    idle(40);

    phase = "R2";
    send(4'b0101, 0); idle(20);
    send(4'b0110, 0); idle(20);
    send(4'b0111, 0); idle(20);
    send(4'b0111, 1); idle(20);   // ignored from the parallel path
    send(4'b1000, 1); idle(20);   // ignored from the parallel path
    send(4'b0100, 1); idle(20);

    phase = "R3";
    send(4'b1000, 0); idle(300);
    phase = "R4";
    send(4'b1001, 0); idle(1400);
    send(4'b1010, 0); idle(4000);
    send(4'b1011, 0); idle(8000);

    phase = "R5";
    send(4'b1000, 0); idle(90);
    send(4'b1100, 0); idle(200);
    send(4'b1100, 0); idle(50);

    phase = "R6";
    send(4'b1110, 0); idle(150);
    send(4'b1101, 0); idle(150);
    send(4'b1110, 0); idle(60);
    send(4'b1101, 0); idle(40);

    phase = "R7";
    send(4'b0110, 0); idle(100);  // serial select: timer keeps going
    send(4'b1000, 0); idle(30);
    send(4'b0101, 1); idle(100);  // parallel select: timer stops
    send(4'b1100, 0); idle(10);

    phase = "R8";
    send(4'b1000, 0); idle(20);
    send(4'b1111, 0); idle(10);
    check(int'(tp_o), 0, "R8");
    send(4'b0000, 0); idle(20);
    check(int'(tp_o), int'(div_tap_i[0]), "R8");
    send(4'b0110, 0); idle(5);
    send(4'b0000, 0); idle(20);   // no test mode: no effect
    send(4'b1111, 1); idle(10);   // parallel path cannot enter test
    send(4'b1111, 0); idle(10);
    send(4'b1001, 0); idle(20);
    send(4'b1111, 0); idle(10);
    send(4'b0101, 0); idle(20);

    phase = "R10";
    send(4'b1000, 0); idle(40);
    send(4'b0010, 0); idle(7);
    send(4'b0001, 1); idle(9);
    send(4'b0011, 0); idle(120);

    phase = "R9";
    for (int k = 0; k < 8; k++) begin
      send(4'b1000, 0); idle(k);
      send(4'b1100, 0); idle(61 + k);
      send(4'b1110, 0); idle(k % 2);
      send(4'b1101, 0); idle(63);
      send(4'b1100, 0); idle(3);
    end
    idle(50);

    done = 1;
    summary();
    $finish;
  end

endmodule